// File: doc/BRIEF.md
# Range Maintenance Command Splitter

This block turns one cache maintenance request over a byte range into an ordered stream of commands for a downstream maintenance engine. A request carries a start address (inclusive), an end address (exclusive) and an operation: invalidate, clean or flush. The splitter aligns the range to 32-byte lines and cuts it into chunks. A chunk never crosses a 4 KiB page and never covers more than 1024 bytes. Each chunk is emitted as an inclusive line-range command. For invalidate requests, the partly covered lines at either edge are written back before they are dropped: each becomes a single-line clean-and-invalidate command.

Commands leave on a valid/ready port, one at a time. The next chunk is worked out only after the current command has been accepted. A write-through mode input removes every clean command, because lines are never dirty in that mode. After the last command of a request is accepted, a one-cycle completion pulse tells the issuer that the stream has drained. This stands in for the barrier that closes a maintenance sequence.

Top module: `maint_range_splitter`

## Requirements
- R1: While reset is held, req_ready, cmd_valid and done are low. Once reset has been released, the block is idle with req_ready high. A request is taken on an edge where req_valid and req_ready are both high. req_ready stays low while any command of that request is pending.
- R2: cmd_kind 0 is a single-line clean-and-invalidate of the line at cmd_lo, with cmd_hi equal to cmd_lo. Kind 1 is a range clean and kind 2 is a range invalidate, each covering every line whose first byte lies in [cmd_lo, cmd_hi]. Both bounds are 32-byte aligned. A range stays inside one 4 KiB page and spans at most 1024 bytes.
- R3: The chunk starting at address C ends (exclusive) at the smallest of three points: the aligned request end, C + 1024, and the next 4 KiB boundary above C. The range command carries cmd_hi = chunk end − 32, and the next chunk starts at that chunk end.
- R4: For invalidate (req_op 0) with a start that is not line aligned, the first command is a kind 0 command on the start's line. Chunking then begins at the next line boundary above the start.
- R5: For invalidate, a kind 0 command on the end's line is issued if the end is not line aligned and the rounded-up start is still below the end. This command follows any start-line command, and chunking then stops at the end rounded down to a line boundary.
- R6: For clean (req_op 1) and flush (req_op 2), the start is rounded down and the end rounded up to 32-byte boundaries before chunking. An end rounded up past the top of the address space is handled without wrap.
- R7: For flush, each chunk yields a range clean followed directly by a range invalidate with identical bounds.
- R8: With wt_mode high at request time, a clean request issues no commands, and a flush request issues only its range invalidate commands.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_kind, cmd_lo and cmd_hi hold their values.
- R10: done is high for exactly one cycle, immediately after the edge that accepts the last command. A request that yields no commands pulses done in the cycle right after its acceptance, and no command is presented while done is high.
- R11: req_op 3 is reserved. It issues no commands and completes as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 reserved |
| req_start | input | ADDR_W | First byte of the range (inclusive) |
| req_end | input | ADDR_W | End of the range (exclusive) |
| wt_mode | input | 1 | Write-through mode, sampled with the request |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Engine accepts the presented command |
| cmd_kind | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmd_lo | output | ADDR_W | Line address, or first line of a range |
| cmd_hi | output | ADDR_W | Last line of a range (inclusive), equal to cmd_lo for kind 0 |
| done | output | 1 | One-cycle pulse when the request's stream has drained |

## Verification
The assertions check properties that must hold on every cycle:
- commands hold steady under back-pressure;
- command bounds are line aligned, and ranges stay inside one page and within the chunk limit;
- a flush clean is always followed at once by the matching invalidate;
- write-through never lets a range clean out;
- req_ready and done never overlap a live command.

Only the bench scenarios can show that a request produces the right commands, in the right order and the right number. That covers edge-line handling for invalidate, rounding for clean and flush, clipping at pages and at the size cap, the empty and reserved cases, and rounding at the top of the address space. The bench checks each of these against a list worked out from the requirements.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_LINE   = 2'd0,
    K_RCLEAN = 2'd1,
    K_RINV   = 2'd2,
    K_NONE   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HEAD  = 3'd1,
    ST_TAIL  = 3'd2,
    ST_CLEAN = 3'd3,
    ST_INV   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/mrs_edge_align.sv
module mrs_edge_align
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] stop_i,
  output logic              head_need_o,
  output logic [ADDR_W-1:0] head_line_o,
  output logic              tail_need_o,
  output logic [ADDR_W-1:0] tail_line_o,
  output logic [ADDR_W:0]   lo_o,
  output logic [ADDR_W:0]   hi_o
);

  localparam int EXT_W    = ADDR_W + 1;
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [EXT_W-1:0] LMASK = EXT_W'(LINE_BYTES - 1);

  logic [EXT_W-1:0] s_ext, e_ext, s_up, s_dn, e_dn, e_up, s_inv;
  logic             s_mis, e_mis, tail_hit;

  // widen by one bit so a rounded-up end at the top of memory does not wrap
  assign s_ext = {1'b0, start_i};
  assign e_ext = {1'b0, stop_i};
  assign s_mis = |start_i[LINE_LSB-1:0];
  assign e_mis = |stop_i[LINE_LSB-1:0];

  assign s_up  = (s_ext | LMASK) + EXT_W'(1);
  assign s_dn  = s_ext & ~LMASK;
  assign e_dn  = e_ext & ~LMASK;
  assign e_up  = (e_ext + LMASK) & ~LMASK;

  // invalidate: a partial first line is handled on its own, chunking begins after it
  assign s_inv    = s_mis ? s_up : s_ext;
  assign tail_hit = e_mis && (s_inv < e_ext);

  assign head_line_o = s_dn[ADDR_W-1:0];
  assign tail_line_o = e_dn[ADDR_W-1:0];

  always_comb begin
    head_need_o = 1'b0;
    tail_need_o = 1'b0;
    lo_o        = '0;
    hi_o        = '0;
    unique case (op_i)
      OP_INV: begin
        head_need_o = s_mis;
        tail_need_o = tail_hit;
        lo_o        = s_inv;
        hi_o        = tail_hit ? e_dn : e_ext;
      end
      OP_CLEAN, OP_FLUSH: begin
        lo_o = s_dn;
        hi_o = e_up;
      end
      default: begin
        lo_o = '0;
        hi_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/mrs_chunk_calc.sv
module mrs_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W:0]   cur_i,
  input  logic [ADDR_W:0]   stop_i,
  output logic [ADDR_W:0]   chunk_end_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] range_hi_o
);

  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] PMASK = EXT_W'(PAGE_BYTES - 1);

  logic [EXT_W-1:0] page_next, clip_page, clip_all;

  assign page_next = (cur_i | PMASK) + EXT_W'(1);
  assign clip_page = (page_next < stop_i) ? page_next : stop_i;

  generate
    if (MAX_CHUNK < PAGE_BYTES) begin : g_cap
      logic [EXT_W-1:0] cap;
      assign cap      = cur_i + EXT_W'(MAX_CHUNK);
      assign clip_all = (cap < clip_page) ? cap : clip_page;
    end else begin : g_nocap
      // a whole page never exceeds the cap, so the page clip alone decides
      assign clip_all = clip_page;
    end
  endgenerate

  assign chunk_end_o = clip_all;
  assign last_o      = (clip_all >= stop_i);
  assign range_hi_o  = clip_all[ADDR_W-1:0] - ADDR_W'(LINE_BYTES);

  always_comb begin
    if (cur_i < stop_i) begin
      // R3
      chunk_grow_chk: assert ((chunk_end_o > cur_i) && (chunk_end_o <= stop_i)
                              && ((chunk_end_o - cur_i) <= EXT_W'(MAX_CHUNK)));
    end
  end

endmodule

// File: rtl/maint_range_splitter.sv
module maint_range_splitter
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_mode,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_lo,
  output logic [ADDR_W-1:0] cmd_hi,
  output logic              done
);

  localparam int EXT_W    = ADDR_W + 1;
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  // ---------------- reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // ---------------- request alignment
  op_e              op_in;
  logic             a_head, a_tail;
  logic [ADDR_W-1:0] a_head_line, a_tail_line;
  logic [EXT_W-1:0] a_lo, a_hi;

  assign op_in = op_e'(req_op);

  mrs_edge_align #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_align (
    .op_i        (op_in),
    .start_i     (req_start),
    .stop_i      (req_end),
    .head_need_o (a_head),
    .head_line_o (a_head_line),
    .tail_need_o (a_tail),
    .tail_line_o (a_tail_line),
    .lo_o        (a_lo),
    .hi_o        (a_hi)
  );

  // ---------------- sequencing state
  seq_state_e        state_q, state_d;
  op_e               op_q;
  logic              wt_q;
  logic              tail_need_q;
  logic [ADDR_W-1:0] head_q, tail_q;
  logic [EXT_W-1:0]  cur_q, cur_d, stop_q;
  logic              done_q, done_d;
  logic              ld_en, cur_en, accept;

  // ---------------- chunk arithmetic on the live cursor
  logic [EXT_W-1:0]  c_end;
  logic              c_last;
  logic [ADDR_W-1:0] c_hi;

  mrs_chunk_calc #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_CHUNK  (MAX_CHUNK),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_chunk (
    .cur_i       (cur_q),
    .stop_i      (stop_q),
    .chunk_end_o (c_end),
    .last_o      (c_last),
    .range_hi_o  (c_hi)
  );

  function automatic seq_state_e entry_state(op_e op, logic wt, logic head,
                                             logic tail, logic rng);
    seq_state_e s;
    unique case (op)
      OP_INV:   s = head ? ST_HEAD : (tail ? ST_TAIL : (rng ? ST_INV : ST_IDLE));
      OP_CLEAN: s = (rng && !wt) ? ST_CLEAN : ST_IDLE;
      OP_FLUSH: s = rng ? (wt ? ST_INV : ST_CLEAN) : ST_IDLE;
      default:  s = ST_IDLE;
    endcase
    return s;
  endfunction

  assign req_ready = rst_q && (state_q == ST_IDLE);
  assign cmd_valid = (state_q != ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // ---------------- next state
  always_comb begin
    state_d = state_q;
    ld_en   = 1'b0;
    cur_en  = 1'b0;
    cur_d   = c_end;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          ld_en   = 1'b1;
          cur_en  = 1'b1;
          cur_d   = a_lo;
          state_d = entry_state(op_in, wt_mode, a_head, a_tail, a_lo < a_hi);
        end
      end
      ST_HEAD: begin
        if (accept) begin
          state_d = tail_need_q ? ST_TAIL : ((cur_q < stop_q) ? ST_INV : ST_IDLE);
        end
      end
      ST_TAIL: begin
        if (accept) begin
          state_d = (cur_q < stop_q) ? ST_INV : ST_IDLE;
        end
      end
      ST_CLEAN: begin
        if (accept) begin
          if (op_q == OP_FLUSH) begin
            state_d = ST_INV;
          end else begin
            cur_en  = 1'b1;
            state_d = c_last ? ST_IDLE : ST_CLEAN;
          end
        end
      end
      ST_INV: begin
        if (accept) begin
          cur_en  = 1'b1;
          state_d = c_last ? ST_IDLE
                  : ((op_q == OP_FLUSH && !wt_q) ? ST_CLEAN : ST_INV);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = (state_q != ST_IDLE) ? (state_d == ST_IDLE)
                                  : (ld_en && (state_d == ST_IDLE));
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      op_q        <= OP_RSVD;
      wt_q        <= 1'b0;
      tail_need_q <= 1'b0;
      head_q      <= '0;
      tail_q      <= '0;
      stop_q      <= '0;
    end else if (ld_en) begin
      op_q        <= op_in;
      wt_q        <= wt_mode;
      tail_need_q <= a_tail;
      head_q      <= a_head_line;
      tail_q      <= a_tail_line;
      stop_q      <= a_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  // ---------------- command outputs
  kind_e kind_now;

  always_comb begin
    unique case (state_q)
      ST_HEAD: begin kind_now = K_LINE;   cmd_lo = head_q;              cmd_hi = head_q; end
      ST_TAIL: begin kind_now = K_LINE;   cmd_lo = tail_q;              cmd_hi = tail_q; end
      ST_CLEAN:begin kind_now = K_RCLEAN; cmd_lo = cur_q[ADDR_W-1:0];   cmd_hi = c_hi;   end
      ST_INV:  begin kind_now = K_RINV;   cmd_lo = cur_q[ADDR_W-1:0];   cmd_hi = c_hi;   end
      default: begin kind_now = K_NONE;   cmd_lo = '0;                  cmd_hi = '0;     end
    endcase
  end

  assign cmd_kind = kind_now;
  assign done     = done_q;

  // ---------------- assertions
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                   && $stable(cmd_lo) && $stable(cmd_hi)));

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_valid |-> ((cmd_lo[LINE_LSB-1:0] == '0) && (cmd_hi[LINE_LSB-1:0] == '0)));

  // R2
  range_page_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && kind_now != K_LINE) |->
      ((cmd_lo[ADDR_W-1:PAGE_LSB] == cmd_hi[ADDR_W-1:PAGE_LSB]) && (cmd_hi >= cmd_lo)
       && ((cmd_hi - cmd_lo) <= ADDR_W'(MAX_CHUNK - LINE_BYTES))));

  // R2
  line_single_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && kind_now == K_LINE) |-> (cmd_lo == cmd_hi));

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_ready |-> !cmd_valid);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> !cmd_valid);

  // R8
  wt_noclean_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && wt_q) |-> (kind_now != K_RCLEAN));

  // R7
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && kind_now == K_RCLEAN && op_q == OP_FLUSH) |=>
      (cmd_valid && kind_now == K_RINV && $stable(cmd_lo) && $stable(cmd_hi)));

endmodule

// File: tb/maint_range_splitter_test.sv
`timescale 1ns/1ps
module maint_range_splitter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, wt_mode, cmd_valid, cmd_ready, done;
  logic [1:0]  req_op, cmd_kind;
  logic [31:0] req_start, req_end, cmd_lo, cmd_hi;

  int n_checks = 0;
  int n_fail   = 0;

  logic [1:0]  ek  [0:63];
  logic [31:0] elo [0:63];
  logic [31:0] ehi [0:63];
  int          en;

  always #2.5 clk = ~clk;

  maint_range_splitter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end), .wt_mode(wt_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [32:0] lo, input logic [32:0] hi);
    if (en < 64) begin
      ek[en] = k; elo[en] = lo[31:0]; ehi[en] = hi[31:0];
      en++;
    end
  endtask

  // expected command list, built from the requirements
  task automatic model(input logic [1:0] op, input logic [31:0] s0, input logic [31:0] e0,
                       input logic wt);
    logic [32:0] s, e, ce, pg;
    s = {1'b0, s0};
    e = {1'b0, e0};
    en = 0;
    if (op == 2'd3) return;
    if (op == 2'd0) begin
      if (s[4:0] != 0) begin
        push(2'd0, s & ~33'h1f, s & ~33'h1f);
        s = (s | 33'h1f) + 1;
      end
      if (s < e && e[4:0] != 0) begin
        push(2'd0, e & ~33'h1f, e & ~33'h1f);
        e = e & ~33'h1f;
      end
    end else begin
      if (op == 2'd1 && wt) return;
      s = s & ~33'h1f;
      e = (e + 33'h1f) & ~33'h1f;
    end
    while (s < e && en < 60) begin
      ce = e;
      if (s + 33'd1024 < ce) ce = s + 33'd1024;
      pg = (s | 33'hfff) + 1;
      if (pg < ce) ce = pg;
      if (op == 2'd1) push(2'd1, s, ce - 33'd32);
      if (op == 2'd2) begin
        if (!wt) push(2'd1, s, ce - 33'd32);
        push(2'd2, s, ce - 33'd32);
      end
      if (op == 2'd0) push(2'd2, s, ce - 33'd32);
      s = ce;
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                         input logic wt, input bit stall, input string tag);
    int          got;
    bit          fin, hold;
    logic [1:0]  hk;
    logic [31:0] hlo, hhi;
    model(op, s, e, wt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_start = s; req_end = e; wt_mode = wt;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; fin = 1'b0; hold = 1'b0;
    hk = '0; hlo = '0; hhi = '0;
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      if (hold) begin
        // R9: command unchanged under back-pressure
        chk(cmd_valid && cmd_kind == hk && cmd_lo == hlo && cmd_hi == hhi, "R9",
            "held command", {5'd0, cmd_valid, cmd_kind, cmd_lo, cmd_hi},
            {5'd0, 1'b1, hk, hlo, hhi});
        hold = 1'b0;
      end
      if (done) begin
        fin = 1'b1;
        chk(got == en, tag, "command count", 72'(got), 72'(en));
        // R10: done only once the stream is drained, block idle again
        chk(!cmd_valid && req_ready, "R10", "state at done",
            {70'd0, cmd_valid, req_ready}, 72'd1);
      end else begin
        cmd_ready = stall ? ((cyc % 3) != 1) : 1'b1;
        if (cmd_valid) begin
          if (cmd_ready) begin
            if (got < en)
              chk(cmd_kind == ek[got] && cmd_lo == elo[got] && cmd_hi == ehi[got], tag,
                  $sformatf("command %0d", got), {6'd0, cmd_kind, cmd_lo, cmd_hi},
                  {6'd0, ek[got], elo[got], ehi[got]});
            else
              chk(1'b0, tag, "extra command", {6'd0, cmd_kind, cmd_lo, cmd_hi}, 72'd0);
            got++;
          end else begin
            hold = 1'b1; hk = cmd_kind; hlo = cmd_lo; hhi = cmd_hi;
          end
        end
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, tag, "no completion", 72'd0, 72'd1);
    cmd_ready = 1'b1;
    @(negedge clk);
    // R10: single-cycle pulse
    chk(!done, "R10", "done pulse width", {71'd0, done}, 72'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet while reset is held
    chk(!req_ready && !cmd_valid && !done, "R1", "outputs in reset",
        {69'd0, req_ready, cmd_valid, done}, 72'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1", "idle after reset",
        {69'd0, req_ready, cmd_valid, done}, 72'h4);
  endtask

  task automatic t_inv_edges;      // R4 R5
    run_req(2'd0, 32'h0000_1004, 32'h0000_10f9, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_inv_chunks;     // R3 R2: page clip then 1024-byte cap
    run_req(2'd0, 32'h0000_2f00, 32'h0000_3900, 1'b0, 1'b0, "R3");
    run_req(2'd0, 32'h0000_6000, 32'h0000_6400, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_inv_tiny;       // R5 tail-line condition
    run_req(2'd0, 32'h0000_0041, 32'h0000_0045, 1'b0, 1'b0, "R5");
    run_req(2'd0, 32'h0000_0040, 32'h0000_0045, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_clean_stall;    // R6 with back-pressure (R9)
    run_req(2'd1, 32'h0000_5013, 32'h0000_5431, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_clean_top;      // R6 end rounds to the top of memory
    run_req(2'd1, 32'hffff_ffc1, 32'hffff_ffff, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_flush;          // R7
    run_req(2'd2, 32'h0000_7fe0, 32'h0000_8050, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_wt;             // R8
    run_req(2'd1, 32'h0000_9000, 32'h0000_9400, 1'b1, 1'b0, "R8");
    run_req(2'd2, 32'h0000_9f80, 32'h0000_a080, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_empty;          // R10
    run_req(2'd1, 32'h0000_0100, 32'h0000_0100, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_reserved;       // R11
    run_req(2'd3, 32'h0000_0000, 32'h0000_0800, 1'b0, 1'b0, "R11");
  endtask

  initial begin
    req_valid = 1'b0; req_op = '0; req_start = '0; req_end = '0;
    wt_mode = 1'b0; cmd_ready = 1'b1;
    t_reset();
    t_inv_edges();
    t_inv_chunks();
    t_inv_tiny();
    t_clean_stall();
    t_clean_top();
    t_flush();
    t_wt();
    t_empty();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule